// File: doc/BRIEF.md
# Packet-Driven Word Copy Engine

The engine takes a six-dword command packet on a valid/ready dword stream, decodes it, and moves 32-bit words from one address space to another. The first dword is the control word, the sixth is the length/option word, and the middle four carry the source and destination addresses. A source can be external memory, an indexed register space, a small internal data-share RAM, or a constant carried in the packet itself. A destination can be memory, register space or the data-share RAM. Either address can be held fixed, so the same packet format covers plain copies, fills and draining a sequence of words into one location.

External memory is reached through a request/response port. Each request carries a 64-bit byte address and a write flag. Only one read is outstanding at a time. A request stays asserted and unchanged until `mem_req_ready` accepts it. A read response is taken in the cycle when both `mem_rsp_valid` and `mem_rsp_ready` are high. The command stream obeys the same valid/ready rule. `cmd_ready` is low while a packet is executing, so a sender may hold `cmd_valid` high for any length of time. Register space is reached through a plain word-indexed port, and register read data is expected in the same cycle as the read strobe. Several option fields are decoded but have no effect: cache policy, byte swap, write-combine disable, sync and volatile bits.

Top module: `pce_top`

## Requirements
- R1: A packet is six dwords taken on `cmd_valid && cmd_ready`, in this order: control, source low, source high, destination low, destination high, length word. `cmd_ready` is low while `busy` is high.
- R2: The byte count is length-word bits 20:0. The number of words moved is the byte count divided by four, with any remainder dropped. A count of zero raises `done` with no memory or register activity.
- R3: Destination select is control bits 21:20. The value 0 selects memory, or register space when length-word bit 27 is set. The value 1 selects the data-share RAM. The value 3 selects memory. The value 2 raises `error`.
- R4: Source select is control bits 30:29. The value 0 selects memory, or register space when length-word bit 26 is set. The value 1 selects the data-share RAM. The value 2 selects the source-low dword as a constant. The value 3 selects memory.
- R5: A register index, and a data-share word index, is the low address dword divided by four. It advances by one per word.
- R6: A memory address is {high dword, low dword} as a 64-bit byte address. It advances by 4 per word.
- R7: Length-word bit 28 holds the source fixed, and bit 29 holds the destination fixed. Each bit applies only when its select is 0 and its side targets memory. A fixed source is read once, and that word is written to every destination word. A fixed destination receives each source word in turn.
- R8: With both sides fixed and a nonzero byte count, exactly one word is moved.
- R9: In constant mode, a byte count above 4 raises `error` and nothing executes.
- R10: An error raises `error` in the same cycle as `done`. No write takes place, and the engine returns to idle.
- R11: A memory request holds its address, write flag and data until it is accepted. Only one read is outstanding at a time.
- R12: After reset `busy`, `done` and `error` are low and `cmd_ready` is high. `done` is a single-cycle pulse, and the engine is idle in the next cycle.
- R13: Data-share words written by one packet can be read by a later packet. These writes are not visible on the memory or register ports.
- R14: Control bits 0, 15, 25–27 and 31, and length-word bits 21, 24, 25 and 30, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Packet dword valid |
| cmd_ready | output | 1 | Engine accepts a dword |
| cmd_data | input | 32 | Packet dword |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_rdata | input | 32 | Read data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_idx | output | REG_IDX_W | Register word index |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, same cycle |
| busy | output | 1 | A packet is executing |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | The packet was rejected; raised together with done |

## Verification
The hardest case to reach is a stall on the memory port that lands in the middle of a transfer: a read request held while `mem_req_ready` is low, a write held behind it, and a fixed source whose single fetched word must still be reused after those stalls. The bench drives `mem_req_ready` from a free-running LFSR, so gaps fall at many different points in fill, fixed-destination and incrementing copies. It then checks the final memory image and the number of writes, not the exact timing. The data-share RAM is visible only through a second packet that copies it back out to memory.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int DW        = 32;
  localparam int PKT_WORDS = 6;
  localparam int LEN_W     = 21;
  localparam int WCNT_W    = LEN_W - 2;

  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_REG = 2'd1,
    SP_GDS = 2'd2,
    SP_IMM = 2'd3
  } space_e;

  typedef struct packed {
    space_e              src_sp;
    space_e              dst_sp;
    logic                src_fix;
    logic                dst_fix;
    logic [63:0]         src_addr;
    logic [63:0]         dst_addr;
    logic [DW-1:0]       imm;
    logic [WCNT_W-1:0]   nwords;
    logic                bad;
  } plan_t;
endpackage

// File: rtl/pce_collect.sv
module pce_collect
  import pce_pkg::*;
#(
  parameter int N = PKT_WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  output logic [N-1:0][DW-1:0]  words,
  output logic                  pkt_pulse
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] cnt;
  logic          take;

  assign in_ready = enable && !pkt_pulse;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pkt_pulse <= 1'b0;
      words     <= '0;
    end else begin
      pkt_pulse <= 1'b0;
      if (take) begin
        words[cnt] <= in_data;
        if (cnt == CW'(N - 1)) begin
          cnt       <= '0;
          pkt_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < N);  // R1
  AST_PULSE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_pulse |-> $past(take));  // R1
endmodule

// File: rtl/pce_decode.sv
module pce_decode
  import pce_pkg::*;
(
  input  logic [PKT_WORDS-1:0][DW-1:0] pkt,
  output plan_t                        plan
);
  logic [DW-1:0]    ctrl, lw;
  logic [1:0]       dsel, ssel;
  logic [LEN_W-1:0] bytes;
  logic             s_regsp, d_regsp, s_hold, d_hold;
  logic             unused_bits;

  assign ctrl    = pkt[0];
  assign lw      = pkt[5];
  assign dsel    = ctrl[21:20];
  assign ssel    = ctrl[30:29];
  assign bytes   = lw[LEN_W-1:0];
  assign s_regsp = lw[26];
  assign d_regsp = lw[27];
  assign s_hold  = lw[28];
  assign d_hold  = lw[29];
  assign unused_bits = ^{ctrl[31], ctrl[28:22], ctrl[19:0], lw[31:30], lw[25:21]};

  always_comb begin
    plan          = '0;
    plan.src_addr = {pkt[2], pkt[1]};
    plan.dst_addr = {pkt[4], pkt[3]};
    plan.imm      = pkt[1];

    unique case (dsel)
      2'd0:    plan.dst_sp = d_regsp ? SP_REG : SP_MEM;
      2'd1:    plan.dst_sp = SP_GDS;
      2'd3:    plan.dst_sp = SP_MEM;
      default: begin plan.dst_sp = SP_MEM; plan.bad = 1'b1; end
    endcase

    unique case (ssel)
      2'd0:    plan.src_sp = s_regsp ? SP_REG : SP_MEM;
      2'd1:    plan.src_sp = SP_GDS;
      2'd2:    plan.src_sp = SP_IMM;
      default: plan.src_sp = SP_MEM;
    endcase

    plan.src_fix = (ssel == 2'd0) && !s_regsp && s_hold;
    plan.dst_fix = (dsel == 2'd0) && !d_regsp && d_hold;

    if (plan.src_fix && plan.dst_fix)
      plan.nwords = (bytes != '0) ? WCNT_W'(1) : '0;
    else
      plan.nwords = bytes[LEN_W-1:2];

    if ((ssel == 2'd2) && (bytes > LEN_W'(4)))
      plan.bad = 1'b1;
  end
endmodule

// File: rtl/pce_gds.sv
module pce_gds
  import pce_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[widx] <= wdata;
  end

  assign rdata = ram[ridx];
endmodule

// File: rtl/pce_mover.sv
module pce_mover
  import pce_pkg::*;
#(
  parameter int RIW = 8,
  parameter int GAW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  plan_t           plan,
  output logic            idle,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [63:0]     mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic            reg_wr_en,
  output logic            reg_rd_en,
  output logic [RIW-1:0]  reg_idx,
  output logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   reg_rdata,
  output logic            gds_we,
  output logic [GAW-1:0]  gds_widx,
  output logic [DW-1:0]   gds_wdata,
  output logic [GAW-1:0]  gds_ridx,
  input  logic [DW-1:0]   gds_rdata,
  output logic            done,
  output logic            error
);
  typedef enum logic [2:0] {M_IDLE, M_FETCH, M_WAIT, M_STORE, M_END} mst_e;

  mst_e              st;
  space_e            ssp_q, dsp_q;
  logic              sfix_q, dfix_q, have_q, bad_q;
  logic [63:0]       saddr_q, daddr_q;
  logic [WCNT_W-1:0] remain_q;
  logic [DW-1:0]     word_q;
  logic              need_fetch, stored;

  assign need_fetch = !(sfix_q && have_q) && (ssp_q != SP_IMM);
  assign stored     = (st == M_STORE) && ((dsp_q != SP_MEM) || mem_req_ready);
  assign idle       = (st == M_IDLE);
  assign done       = (st == M_END);
  assign error      = (st == M_END) && bad_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_rsp_ready = 1'b0;
    reg_wr_en     = 1'b0;
    reg_rd_en     = 1'b0;
    gds_we        = 1'b0;
    mem_req_addr  = (st == M_STORE) ? daddr_q : saddr_q;
    reg_idx       = (st == M_STORE) ? daddr_q[RIW+1:2] : saddr_q[RIW+1:2];
    mem_req_wdata = word_q;
    reg_wdata     = word_q;
    gds_wdata     = word_q;
    gds_widx      = daddr_q[GAW+1:2];
    gds_ridx      = saddr_q[GAW+1:2];
    unique case (st)
      M_FETCH: if (need_fetch) begin
        if (ssp_q == SP_MEM) mem_req_valid = 1'b1;
        if (ssp_q == SP_REG) reg_rd_en = 1'b1;
      end
      M_WAIT:  mem_rsp_ready = 1'b1;
      M_STORE: begin
        unique case (dsp_q)
          SP_MEM:  begin mem_req_valid = 1'b1; mem_req_write = 1'b1; end
          SP_REG:  reg_wr_en = 1'b1;
          SP_GDS:  gds_we = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      ssp_q    <= SP_MEM;
      dsp_q    <= SP_MEM;
      sfix_q   <= 1'b0;
      dfix_q   <= 1'b0;
      have_q   <= 1'b0;
      bad_q    <= 1'b0;
      saddr_q  <= '0;
      daddr_q  <= '0;
      remain_q <= '0;
      word_q   <= '0;
    end else begin
      unique case (st)
        M_IDLE: if (start) begin
          ssp_q    <= plan.src_sp;
          dsp_q    <= plan.dst_sp;
          sfix_q   <= plan.src_fix;
          dfix_q   <= plan.dst_fix;
          saddr_q  <= plan.src_addr;
          daddr_q  <= plan.dst_addr;
          remain_q <= plan.nwords;
          word_q   <= plan.imm;
          have_q   <= 1'b0;
          bad_q    <= plan.bad;
          if (plan.bad || (plan.nwords == '0)) st <= M_END;
          else                                 st <= M_FETCH;
        end
        M_FETCH: begin
          if (!need_fetch) st <= M_STORE;
          else begin
            unique case (ssp_q)
              SP_MEM: if (mem_req_ready) st <= M_WAIT;
              SP_REG: begin word_q <= reg_rdata; st <= M_STORE; end
              SP_GDS: begin word_q <= gds_rdata; st <= M_STORE; end
              default: st <= M_STORE;
            endcase
          end
        end
        M_WAIT: if (mem_rsp_valid) begin
          word_q <= mem_rsp_rdata;
          st     <= M_STORE;
        end
        M_STORE: if (stored) begin
          have_q   <= 1'b1;
          remain_q <= remain_q - 1'b1;
          if (!sfix_q && (ssp_q != SP_IMM)) saddr_q <= saddr_q + 64'd4;
          if (!dfix_q)                      daddr_q <= daddr_q + 64'd4;
          st <= (remain_q == WCNT_W'(1)) ? M_END : M_FETCH;
        end
        default: begin
          st    <= M_IDLE;
          bad_q <= 1'b0;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));  // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && idle));  // R12
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> !(mem_req_valid && mem_req_write) && !reg_wr_en && !gds_we);  // R10
  AST_FIX_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && dfix_q) |=> $stable(daddr_q));  // R7
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);  // R11
endmodule

// File: rtl/pce_top.sv
module pce_top
  import pce_pkg::*;
#(
  parameter int REG_IDX_W = 8,
  parameter int GDS_WORDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [31:0]          cmd_data,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [63:0]          mem_req_addr,
  output logic [31:0]          mem_req_wdata,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [31:0]          mem_rsp_rdata,
  output logic                 reg_wr_en,
  output logic                 reg_rd_en,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [31:0]          reg_wdata,
  input  logic [31:0]          reg_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 error
);
  localparam int GAW = $clog2(GDS_WORDS);

  logic [PKT_WORDS-1:0][DW-1:0] words;
  logic                         pkt_pulse, mv_idle;
  plan_t                        plan;
  logic                         gds_we;
  logic [GAW-1:0]               gds_widx, gds_ridx;
  logic [DW-1:0]                gds_wdata, gds_rdata;

  assign busy = !mv_idle || pkt_pulse;

  pce_collect #(.N(PKT_WORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .enable(mv_idle),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data(cmd_data),
    .words(words), .pkt_pulse(pkt_pulse)
  );

  pce_decode u_decode (.pkt(words), .plan(plan));

  pce_gds #(.WORDS(GDS_WORDS)) u_gds (
    .clk(clk), .we(gds_we), .widx(gds_widx), .wdata(gds_wdata),
    .ridx(gds_ridx), .rdata(gds_rdata)
  );

  pce_mover #(.RIW(REG_IDX_W), .GAW(GAW)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(pkt_pulse), .plan(plan), .idle(mv_idle),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gds_we(gds_we), .gds_widx(gds_widx), .gds_wdata(gds_wdata),
    .gds_ridx(gds_ridx), .gds_rdata(gds_rdata),
    .done(done), .error(error)
  );

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);  // R1
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && !(mem_req_valid || reg_wr_en || reg_rd_en)));  // R10
endmodule

// File: tb/sim_pce_top.sv
module sim_pce_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata;
  logic        mem_rsp_valid = 1'b0;
  logic        reg_wr_en, reg_rd_en;
  logic [7:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        busy, done, error;

  always #10 clk = ~clk;  // 50 MHz

  pce_top u0 (.*);

  logic [31:0] mem_m [256];
  logic [31:0] reg_m [256];
  logic [7:0]  lfsr = 8'hA5;
  int          nwr = 0, nacts = 0;
  logic [63:0] last_raddr = '0, last_waddr = '0;
  logic [31:0] rsp_d = '0;
  int          tests = 0, fails = 0;

  assign mem_req_ready = lfsr[0] | lfsr[2];
  assign mem_rsp_rdata = rsp_d;
  assign reg_rdata     = reg_m[reg_idx];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      nacts <= nacts + 1;
      if (mem_req_write) begin
        mem_m[mem_req_addr[9:2]] <= mem_req_wdata;
        nwr        <= nwr + 1;
        last_waddr <= mem_req_addr;
      end else begin
        rsp_d         <= mem_m[mem_req_addr[9:2]];
        mem_rsp_valid <= 1'b1;
        last_raddr    <= mem_req_addr;
      end
    end
    if (reg_wr_en) begin
      reg_m[reg_idx] <= reg_wdata;
      nwr   <= nwr + 1;
      nacts <= nacts + 1;
    end
    if (reg_rd_en) nacts <= nacts + 1;
  end

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] ctrl, slo, shi, dlo, dhi, lw;
    logic        err;
    logic        sp;
    logic [7:0]  idx;
    logic [31:0] val;
    logic [7:0]  nw;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{"R1 ", 32'h0,         32'h40,       0, 32'h100, 0, 32'h0000_000C, 0, 0, 8'd66,  32'hA000_0012, 8'd3},
    '{"R4 ", 32'h4000_0000, 32'hDEADBEEF, 0, 32'h80,  0, 32'h0000_0004, 0, 0, 8'd32,  32'hDEADBEEF, 8'd1},
    '{"R9 ", 32'h4000_0000, 32'hDEADBEEF, 0, 32'h80,  0, 32'h0000_0008, 1, 0, 8'd32,  32'hA000_0020, 8'd0},
    '{"R3 ", 32'h0020_0000, 32'h40,       0, 32'h100, 0, 32'h0000_000C, 1, 0, 8'd64,  32'hA000_0040, 8'd0},
    '{"R7 ", 32'h0,         32'h10,       0, 32'h200, 0, 32'h1000_0010, 0, 0, 8'd131, 32'hA000_0004, 8'd4},
    '{"R7 ", 32'h0,         32'h20,       0, 32'h300, 0, 32'h2000_000C, 0, 0, 8'd192, 32'hA000_000A, 8'd3},
    '{"R8 ", 32'h0,         32'h20,       0, 32'h300, 0, 32'h3000_0028, 0, 0, 8'd192, 32'hA000_0008, 8'd1},
    '{"R5 ", 32'h0,         32'h50,       0, 32'h14,  0, 32'h0800_0008, 0, 1, 8'd6,   32'hA000_0015, 8'd2},
    '{"R5 ", 32'h0030_0000, 32'h08,       0, 32'h40,  0, 32'h0400_0008, 0, 0, 8'd17,  32'hB000_0003, 8'd2},
    '{"R2 ", 32'h0,         32'h0,        0, 32'h190, 0, 32'h0000_0007, 0, 0, 8'd100, 32'hA000_0000, 8'd1},
    '{"R2 ", 32'h0,         32'h0,        0, 32'h190, 0, 32'h0000_0000, 0, 0, 8'd100, 32'hA000_0064, 8'd0},
    '{"R7 ", 32'h6030_0000, 32'h0,        0, 32'h320, 0, 32'h3000_0008, 0, 0, 8'd201, 32'hA000_0001, 8'd2},
    '{"R14", 32'h8E00_8001, 32'h40,       0, 32'h100, 0, 32'h4320_000C, 0, 0, 8'd66,  32'hA000_0012, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload();
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = 32'hA000_0000 + 32'(i);
      reg_m[i] = 32'hB000_0000 + 32'(i);
    end
  endtask

  task automatic run_pkt(input logic [31:0] w0, w1, w2, w3, w4, w5, output logic err_o);
    logic [31:0] pk [6];
    int          t;
    pk = '{w0, w1, w2, w3, w4, w5};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = pk[i];
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk(1'b0, "watchdog", 64'(t), 64'd0);
    err_o = error;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic e;
    int   w0, a0;
    preload();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !error && cmd_ready && !mem_req_valid, "R12 reset",
        {busy, done, error, cmd_ready, mem_req_valid}, 64'b00010);

    for (int i = 0; i < NV; i++) begin
      preload();
      w0 = nwr;
      run_pkt(VEC[i].ctrl, VEC[i].slo, VEC[i].shi, VEC[i].dlo, VEC[i].dhi, VEC[i].lw, e);
      chk(e == VEC[i].err, {string'(VEC[i].tag), " error"}, 64'(e), 64'(VEC[i].err));
      chk(nwr - w0 == int'(VEC[i].nw), {string'(VEC[i].tag), " writes"}, 64'(nwr - w0), 64'(VEC[i].nw));
      if (VEC[i].sp)
        chk(reg_m[VEC[i].idx] == VEC[i].val, {string'(VEC[i].tag), " reg"}, 64'(reg_m[VEC[i].idx]), 64'(VEC[i].val));
      else
        chk(mem_m[VEC[i].idx] == VEC[i].val, {string'(VEC[i].tag), " mem"}, 64'(mem_m[VEC[i].idx]), 64'(VEC[i].val));
    end

    // R2 zero count: no bus activity at all
    preload();
    a0 = nacts;
    run_pkt(32'h0, 32'h0, 0, 32'h190, 0, 32'h0, e);
    chk(nacts == a0 && !e, "R2 zero activity", 64'(nacts - a0), 64'd0);

    // R13 data-share RAM: write via one packet, read back with another
    preload();
    w0 = nwr;
    run_pkt(32'h0010_0000, 32'hA0, 0, 32'h10, 0, 32'h8, e);
    chk(nwr == w0, "R13 hidden writes", 64'(nwr - w0), 64'd0);
    run_pkt(32'h2000_0000, 32'h14, 0, 32'hC8, 0, 32'h4, e);
    chk(mem_m[50] == 32'hA000_0029, "R13 readback", 64'(mem_m[50]), 64'hA000_0029);

    // R6 64-bit address formation
    run_pkt(32'h0, 32'h4, 32'h1, 32'h8, 32'h2, 32'h4, e);
    chk(last_raddr == 64'h1_0000_0004, "R6 read addr", last_raddr, 64'h1_0000_0004);
    chk(last_waddr == 64'h2_0000_0008, "R6 write addr", last_waddr, 64'h2_0000_0008);

    // R1 / R12 busy blocks command stream, then returns to idle
    preload();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = (i == 5) ? 32'h10 : (i == 3) ? 32'h100 : 32'h0;
      @(posedge clk);
    end
    @(negedge clk);
    chk(busy && !cmd_ready, "R1 busy gate", {busy, cmd_ready}, 64'b10);
    while (!done) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !done && cmd_ready, "R12 idle after done", {busy, done, cmd_ready}, 64'b001);

    // R10 recovery after error: next packet executes
    run_pkt(32'h0020_0000, 0, 0, 0, 0, 32'h4, e);
    chk(e, "R10 error", 64'(e), 64'd1);
    run_pkt(32'h4000_0000, 32'h1234_5678, 0, 32'h3FC, 0, 32'h4, e);
    chk(!e && mem_m[255] == 32'h1234_5678, "R10 recover", 64'(mem_m[255]), 64'h1234_5678);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule